// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (sign bit, 8-bit exponent stored with an offset of 127, 23-bit fraction behind an implied leading one) and delivers a 32-bit product in the same format. It is purely combinational: the product follows the operands within the same cycle, so a surrounding pipeline can place registers on either side as its timing budget allows.

The datapath forms the sign as the exclusive-or of the operand signs, adds the stored exponents and removes one offset, multiplies the two 24-bit significands into a 48-bit product, shifts that product right by at most one place, and keeps the top 23 fraction bits with no rounding increment. An operand with a zero exponent field is taken as zero, which forces a zero magnitude while the sign stays the exclusive-or of the two signs. Operands are restricted to normal numbers and exact zeros, and the caller keeps exponents in a range where the result cannot overflow or underflow.

Top module: `fmul_trunc`

## Requirements
- R1: For two nonzero operands, result bit 31 equals operand A bit 31 XOR operand B bit 31.
- R2: When the product of the two significands (each 1.fraction) is below 2, the result exponent field (bits 30:23) equals expA + expB - 127 and the result fraction (bits 22:0) is significand-product bits 45:23.
- R3: When the significand product is 2 or more, the result exponent field equals expA + expB - 126 and the result fraction is significand-product bits 46:24.
- R4: Product bits below the kept fraction are discarded without rounding up: 0x3ffffff8 times 0x3ffffff8 gives 0x407ffff0, and 0x3ffffff8 times 0x3eaaaaab gives 0x3f2aaaa5.
- R5: An operand whose exponent field is zero is a zero: the result bits 30:0 are all zero and bit 31 is the XOR of the operand signs (0x00000000 times 0xbf800000 gives 0x80000000; 0x80000000 times 0x00000000 gives 0x80000000).
- R6: The result is a combinational function of the operands, valid in the same cycle the operands are applied, and carries no X or Z bits for fully defined operands.
- R7: When one nonzero operand has an all-zero fraction, the result fraction equals the other operand's fraction exactly, with no normalization shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand: bit 31 sign, bits 30:23 exponent, bits 22:0 fraction |
| op_b | input | 32 | Second operand, same layout as op_a |
| prod | output | 32 | Truncated product, same layout |

## Verification
The checker assumes that every operand is either an exact zero or a normal number and that the exponent sum minus the offset, plus one, stays between 1 and 254; its exponent-range and power-of-two properties are meaningful only under that promise. The random stimulus draws each exponent field from 64 to 190, which keeps any normalized result exponent inside 1 to 254, and inserts zeros only as whole zero words of either sign. Directed vectors cover the truncation cases, signed zeros and multiplication by powers of two, where the fraction must pass through untouched.

// File: rtl/fmul_trunc_pkg.sv
package fmul_trunc_pkg;

  // Default field sizes of the 32-bit binary format.
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;

  // Exponent offset for a given exponent width.
  function automatic int exp_offset(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/fmul_trunc_unpack.sv
module fmul_trunc_unpack #(
  parameter int EXP_W  = fmul_trunc_pkg::DEF_EXP_W,
  parameter int FRAC_W = fmul_trunc_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [SIG_W-1:0]  sig,
  output logic              is_zero
);

  always_comb begin
    sign    = word[WORD_W-1];
    expo    = word[WORD_W-2 -: EXP_W];
    is_zero = (expo == '0);
    // Hidden one restored for normal numbers only.
    sig     = {~is_zero, word[FRAC_W-1:0]};
  end

endmodule

// File: rtl/fmul_trunc_sigmul.sv
module fmul_trunc_sigmul #(
  parameter int SIG_W = fmul_trunc_pkg::DEF_FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [PROD_W-1:0] sig_p
);

  logic [PROD_W-1:0] partial [SIG_W];

  // One shifted copy of sig_a per set bit of sig_b.
  for (genvar i = 0; i < SIG_W; i++) begin : g_pp
    assign partial[i] = sig_b[i] ? (PROD_W'(sig_a) << i) : '0;
  end

  always_comb begin
    sig_p = '0;
    for (int i = 0; i < SIG_W; i++) begin
      sig_p = sig_p + partial[i];
    end
  end

endmodule

// File: rtl/fmul_trunc_norm.sv
module fmul_trunc_norm #(
  parameter int EXP_W  = fmul_trunc_pkg::DEF_EXP_W,
  parameter int FRAC_W = fmul_trunc_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int TOP    = PROD_W - 1,
  localparam int SUM_W  = EXP_W + 2,
  localparam int OFFSET = fmul_trunc_pkg::exp_offset(EXP_W)
) (
  input  logic [PROD_W-1:0] sig_p,
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic              sign,
  input  logic              zero_in,
  output logic [WORD_W-1:0] word
);

  logic              shift1;
  logic [FRAC_W-1:0] frac_kept;
  logic [SUM_W-1:0]  exp_sum;

  always_comb begin
    shift1    = sig_p[TOP];
    // Truncation: the bits below the kept window are dropped.
    frac_kept = shift1 ? sig_p[TOP-1 -: FRAC_W] : sig_p[TOP-2 -: FRAC_W];
    exp_sum   = SUM_W'(exp_a) + SUM_W'(exp_b) + SUM_W'(shift1) - SUM_W'(OFFSET);
    if (zero_in) begin
      word = {sign, {(WORD_W-1){1'b0}}};
    end else begin
      word = {sign, exp_sum[EXP_W-1:0], frac_kept};
    end
  end

endmodule

// File: rtl/fmul_trunc.sv
module fmul_trunc #(
  parameter int EXP_W  = fmul_trunc_pkg::DEF_EXP_W,
  parameter int FRAC_W = fmul_trunc_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] prod
);

  logic              sgn_a, sgn_b, zer_a, zer_b;
  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [SIG_W-1:0]  sig_a, sig_b;
  logic [PROD_W-1:0] sig_p;

  fmul_trunc_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unp_a_i (
    .word(op_a), .sign(sgn_a), .expo(exp_a), .sig(sig_a), .is_zero(zer_a)
  );

  fmul_trunc_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unp_b_i (
    .word(op_b), .sign(sgn_b), .expo(exp_b), .sig(sig_b), .is_zero(zer_b)
  );

  fmul_trunc_sigmul #(.SIG_W(SIG_W)) mul_i (
    .sig_a(sig_a), .sig_b(sig_b), .sig_p(sig_p)
  );

  fmul_trunc_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) norm_i (
    .sig_p  (sig_p),
    .exp_a  (exp_a),
    .exp_b  (exp_b),
    .sign   (sgn_a ^ sgn_b),
    .zero_in(zer_a | zer_b),
    .word   (prod)
  );

endmodule

// File: rtl/fmul_trunc_chk.sv
module fmul_trunc_chk #(
  parameter int EXP_W  = fmul_trunc_pkg::DEF_EXP_W,
  parameter int FRAC_W = fmul_trunc_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int OFFSET = fmul_trunc_pkg::exp_offset(EXP_W)
) (
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic [WORD_W-1:0] prod
);

  int ea, eb, ez;
  logic za, zb;

  always_comb begin
    ea = int'(op_a[WORD_W-2 -: EXP_W]);
    eb = int'(op_b[WORD_W-2 -: EXP_W]);
    ez = int'(prod[WORD_W-2 -: EXP_W]);
    za = (ea == 0);
    zb = (eb == 0);
    if (!$isunknown({op_a, op_b})) begin
      a_r6_no_x: assert (!$isunknown(prod))
        else $error("R6: unknown bits on product");
      if (za || zb) begin
        a_r5_zero_mag: assert (prod[WORD_W-2:0] == '0)
          else $error("R5: zero operand gave nonzero magnitude");
      end else begin
        a_r1_sign: assert (prod[WORD_W-1] == (op_a[WORD_W-1] ^ op_b[WORD_W-1]))
          else $error("R1: sign mismatch");
        // R2 / R3: exponent is the plain sum or one above it.
        a_r2_r3_exp_range: assert ((ez == ea + eb - OFFSET) || (ez == ea + eb - OFFSET + 1))
          else $error("R2/R3: exponent out of range");
        if (op_a[FRAC_W-1:0] == '0) begin
          a_r7_pow2_frac: assert ((prod[FRAC_W-1:0] == op_b[FRAC_W-1:0]) && (ez == ea + eb - OFFSET))
            else $error("R7: power-of-two scaling altered fraction");
        end
      end
    end
  end

endmodule

bind fmul_trunc fmul_trunc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/fmul_trunc_tb_top.sv
`timescale 1ns/1ps
module fmul_trunc_tb_top;

  logic        clk;
  logic [31:0] op_a, op_b, prod;
  int n_chk, n_fail;
  logic done;

  fmul_trunc dut_i (.op_a(op_a), .op_b(op_b), .prod(prod));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference built on double arithmetic: 24x24-bit products are exact there.
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    real         ma, mb, r;
    logic [63:0] rb;
    int          bump, e;
    s = a[31] ^ b[31];
    if (a[30:23] == 8'd0 || b[30:23] == 8'd0) return {s, 31'd0};
    ma = 1.0 + real'(a[22:0]) / 8388608.0;
    mb = 1.0 + real'(b[22:0]) / 8388608.0;
    r  = ma * mb;
    rb = $realtobits(r);
    bump = int'(rb[62:52]) - 1023;
    e = int'(a[30:23]) + int'(b[30:23]) - 127 + bump;
    return {s, e[7:0], rb[51:29]};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expv, input string tag);
    @(posedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    n_chk++;
    if (prod !== expv) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h got %h expected %h", tag, a, b, prod, expv);
    end
  endtask

  function automatic logic [31:0] rnd_normal();
    logic [31:0] w;
    w = $urandom();
    w[30:23] = 8'(64 + ($urandom() % 127));
    return w;
  endfunction

  // Watchdog
  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    op_a = '0;
    op_b = '0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // Initial state with zero operands: R5 / R6
    n_chk++;
    if (prod !== 32'h0) begin
      n_fail++;
      $display("FAIL R5 idle: got %h expected %h", prod, 32'h0);
    end

    // Directed: signs and unit values (R1, R2)
    apply(32'h3f800000, 32'h3f800000, 32'h3f800000, "R2 one*one");
    apply(32'hbf800000, 32'h3f800000, 32'hbf800000, "R1 neg*pos");
    apply(32'hbf800000, 32'hbf800000, 32'h3f800000, "R1 neg*neg");
    apply(32'h3eaaaaab, 32'h3f800000, 32'h3eaaaaab, "R7 third*one");
    // Truncation (R4, R3)
    apply(32'h3ffffff8, 32'h3ffffff8, 32'h407ffff0, "R4 R3 trunc square");
    apply(32'hbffffff8, 32'h3ffffff8, 32'hc07ffff0, "R4 R1 trunc neg");
    apply(32'h3ffffff8, 32'h3eaaaaab, 32'h3f2aaaa5, "R4 trunc third");
    apply(32'h3eaaaaab, 32'h3eaaaaab, ref_mul(32'h3eaaaaab, 32'h3eaaaaab), "R4 R2 third squared");
    // Largest significands: shift occurs (R3)
    apply(32'h3fffffff, 32'h3fffffff, ref_mul(32'h3fffffff, 32'h3fffffff), "R3 max sig");
    // Signed zeros (R5)
    apply(32'h00000000, 32'h3f800000, 32'h00000000, "R5 zero*pos");
    apply(32'h00000000, 32'hbf800000, 32'h80000000, "R5 zero*neg");
    apply(32'h00000000, 32'h00000000, 32'h00000000, "R5 zero*zero");
    apply(32'h80000000, 32'h00000000, 32'h80000000, "R5 negzero*zero");
    apply(32'hbf800000, 32'h00000000, 32'h80000000, "R5 neg*zero");
    apply(32'h80000000, 32'h80000000, 32'h00000000, "R5 negzero*negzero");

    // Random normals (R1, R2, R3, R6)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, e;
      int raw;
      a = rnd_normal();
      b = rnd_normal();
      e = ref_mul(a, b);
      raw = int'(a[30:23]) + int'(b[30:23]) - 127;
      apply(a, b, e, (int'(e[30:23]) == raw) ? "R1 R2 R6 random" : "R1 R3 R6 random");
    end

    // Power-of-two scaling (R7)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, e;
      a = rnd_normal();
      a[22:0] = '0;
      b = rnd_normal();
      e = ref_mul(a, b);
      apply(a, b, e, "R7 pow2 random");
      apply(b, a, e, "R7 pow2 swapped");
    end

    // Random zero against random normals (R5)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, z;
      a = rnd_normal();
      z = {1'($urandom()), 31'd0};
      apply(z, a, {z[31] ^ a[31], 31'd0}, "R5 zero random");
      apply(a, z, {z[31] ^ a[31], 31'd0}, "R5 zero random swapped");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule